// File: doc/BRIEF.md
# DRAM Refresh Interval Timer

This block paces refresh for an asynchronous DRAM controller. A prescaler divides the system clock by a power of two chosen through a 3-bit select field. Each prescaled tick advances an 8-bit counter. When the next count would equal a programmable compare value, the counter returns to zero, a sticky status flag is set, and a refresh request is raised toward the controller. The request holds until the controller acknowledges it.

Software programs the block through a small register port. The control register holds an enable bit, a mode bit and the select field. When the mode bit selects self-refresh, periodic requests are held back and a self-refresh level is driven out instead. While the select field is zero the counter is frozen, so the count and compare values can be set up safely before the timer is started.

Top module: `refresh_timer`

## Requirements
- R1: After reset every register reads zero, the counter is stopped, `req` is 0 and `self_ref` is 0.
- R2: The register at address 2 holds the compare value and the register at address 1 holds the counter. While the select field is 000 the counter does not change except by a write, and both registers can be written and read back.
- R3: Select codes 1 to 7 make the counter advance once every 2, 8, 32, 128, 512, 2048 or 4096 system clocks. The prescaler is held at zero while the code is 000, and the first tick comes one full divisor period after the code becomes non-zero.
- R4: On a tick where the incremented count equals the compare value, the counter loads 0 instead. With compare value C ≥ 1 and divisor D, matches are therefore C·D clocks apart. With C = 0 they are 256·D clocks apart.
- R5: A match sets the flag (control bit 7) and registers a pending request on the same clock edge. `req` is driven only in refresh mode, that is enable (control bit 0) = 1 and mode (control bit 1) = 0.
- R6: `req` stays high until `ack` is sampled high. A match in the same cycle as `ack` keeps it pending, and several matches before `ack` make up one request.
- R7: With enable = 1 and mode = 1, `self_ref` is 1 and `req` stays 0. Any pending request is dropped whenever refresh mode is left.
- R8: Writing control bit 7 as 0 clears the flag only if the flag was read as 1 from address 0 since the last control write, and the enable bit held before the write is 0. With enable = 1 such writes leave the flag set.
- R9: A counter write takes priority over a tick in the same cycle and never produces a match by itself. Counting then continues from the written value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe; arms the flag-clear handshake |
| addr | input | 2 | Register select: 0 control, 1 counter, 2 compare |
| wdata | input | 8 | Write data; control bits [4:2] select, [1] mode, [0] enable |
| rdata | output | 8 | Read data for `addr`; control adds the flag in bit 7 |
| ack | input | 1 | Refresh acknowledge from the DRAM controller |
| req | output | 1 | Refresh request, held until acknowledged |
| self_ref | output | 1 | Self-refresh mode indicator |

## Verification
The assertions assume that `ack`, the strobes and the address change only between clock edges and are steady around each rising edge. They also assume that a request, once raised, is left alone unless it is acknowledged or the control register is written. The stimulus drives every input on the falling edge. Reads, writes and acknowledges are random, and the select codes are weighted toward short divisors so that matches, overlapping matches and acknowledges that coincide with a match all occur often. Directed passes cover the divisor period, the flag-clear handshake with refresh enabled and with it disabled, and a counter write that equals the compare value.

// File: rtl/refresh_timer.sv
module refresh_timer #(
  parameter int CW = 8,
  parameter int PW = 12
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic          rd_en,
  input  logic [1:0]    addr,
  input  logic [CW-1:0] wdata,
  output logic [CW-1:0] rdata,
  input  logic          ack,
  output logic          req,
  output logic          self_ref
);

  logic          en, mode, flag, armed, pend;
  logic [2:0]    sel;
  logic [CW-1:0] cnt, cmp;
  logic [PW-1:0] pre, msk;

  always_comb begin
    case (sel)
      3'd1:    msk = PW'((1 << 1) - 1);
      3'd2:    msk = PW'((1 << 3) - 1);
      3'd3:    msk = PW'((1 << 5) - 1);
      3'd4:    msk = PW'((1 << 7) - 1);
      3'd5:    msk = PW'((1 << 9) - 1);
      3'd6:    msk = PW'((1 << 11) - 1);
      3'd7:    msk = PW'((1 << 12) - 1);
      default: msk = '0;
    endcase
  end

  wire ctl_wr   = wr_en && addr == 2'd0;
  wire cnt_wr   = wr_en && addr == 2'd1;
  wire cmp_wr   = wr_en && addr == 2'd2;
  wire tick     = sel != 3'd0 && (pre & msk) == msk;
  wire [CW-1:0] cnt_inc = cnt + CW'(1);
  wire hit      = tick && !cnt_wr && cnt_inc == cmp;
  wire cbr      = en && !mode;
  wire clear_ok = ctl_wr && !wdata[7] && armed && !en;

  assign req      = pend && cbr;
  assign self_ref = en && mode;

  always_comb begin
    case (addr)
      2'd0:    rdata = CW'({flag, 2'b00, sel, mode, en});
      2'd1:    rdata = cnt;
      2'd2:    rdata = cmp;
      default: rdata = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en <= 1'b0; mode <= 1'b0; sel <= '0; flag <= 1'b0;
      armed <= 1'b0; pend <= 1'b0; cnt <= '0; cmp <= '0; pre <= '0;
    end else begin
      pre <= (sel == 3'd0) ? '0 : pre + PW'(1);
      if (cnt_wr)    cnt <= wdata;
      else if (hit)  cnt <= '0;
      else if (tick) cnt <= cnt_inc;
      if (cmp_wr) cmp <= wdata;
      if (ctl_wr) {sel, mode, en} <= wdata[4:0];
      if (hit)           flag <= 1'b1;
      else if (clear_ok) flag <= 1'b0;
      if (ctl_wr)                            armed <= 1'b0;
      else if (rd_en && addr == 2'd0 && flag) armed <= 1'b1;
      if (hit && cbr)     pend <= 1'b1;
      else if (ack || !cbr) pend <= 1'b0;
    end
  end

  assert_frozen_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (sel == 3'd0 && !cnt_wr) |=> $stable(cnt));

  assert_restart_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flag) |-> cnt == '0);

  assert_req_held_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (req && !ack && !ctl_wr) |=> req);

  assert_flag_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (flag && en) |=> flag);

endmodule

// File: tb/test_refresh_timer.sv
module test_refresh_timer;
  localparam int T = 10;

  logic clk = 1'b0, rst_n = 1'b0, wr_en = 1'b0, rd_en = 1'b0, ack = 1'b0;
  logic [1:0] addr = '0;
  logic [7:0] wdata = '0, rdata;
  logic req, self_ref;
  int n_cmp = 0, n_bad = 0;
  bit auto_on = 1'b0;

  always #(T/2) clk = ~clk;

  refresh_timer i_refresh_timer (.clk, .rst_n, .wr_en, .rd_en, .addr, .wdata,
                                 .rdata, .ack, .req, .self_ref);

  logic m_en = 0, m_mode = 0, m_flag = 0, m_armed = 0, m_pend = 0;
  logic [2:0] m_sel = 0;
  logic [7:0] m_cnt = 0, m_cmp = 0;
  logic [11:0] m_pre = 0;

  function automatic logic [11:0] exp_mask(input logic [2:0] s);
    int sh [8] = '{0, 1, 3, 5, 7, 9, 11, 12};
    return 12'((1 << sh[s]) - 1);
  endfunction

  function automatic logic [7:0] exp_rdata(input logic [1:0] a);
    if (a == 0) return {m_flag, 2'b00, m_sel, m_mode, m_en};
    if (a == 1) return m_cnt;
    if (a == 2) return m_cmp;
    return 8'h00;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_en = 0; m_mode = 0; m_flag = 0; m_armed = 0; m_pend = 0;
      m_sel = 0; m_cnt = 0; m_cmp = 0; m_pre = 0;
    end else begin
      logic tk, ht, cbr, clr, cw;
      cw  = wr_en && addr == 1;
      tk  = m_sel != 0 && (m_pre & exp_mask(m_sel)) == exp_mask(m_sel);
      ht  = tk && !cw && 8'(m_cnt + 1) == m_cmp;
      cbr = m_en && !m_mode;
      clr = wr_en && addr == 0 && !wdata[7] && m_armed && !m_en;
      m_pre = (m_sel == 0) ? 12'd0 : m_pre + 12'd1;
      if (cw) m_cnt = wdata; else if (ht) m_cnt = 0; else if (tk) m_cnt = m_cnt + 1;
      if (wr_en && addr == 2) m_cmp = wdata;
      if (ht) m_flag = 1; else if (clr) m_flag = 0;
      if (wr_en && addr == 0) m_armed = 0;
      else if (rd_en && addr == 0 && m_flag) m_armed = 1;
      if (ht && cbr) m_pend = 1; else if (ack || !cbr) m_pend = 0;
      if (wr_en && addr == 0) {m_sel, m_mode, m_en} = wdata[4:0];
    end
  end

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
    end
  endtask

  always @(posedge clk) begin
    #(T/4);
    if (auto_on && rst_n) begin
      check("R5 R6 req", 32'(req), 32'(m_pend && m_en && !m_mode));
      check("R7 self_ref", 32'(self_ref), 32'(m_en && m_mode));
      check(addr == 0 ? "R8 control" : addr == 1 ? "R4 counter" : "R2 compare",
            32'(rdata), 32'(exp_rdata(addr)));
    end
  end

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk); wr_en = 1; addr = a; wdata = d;
    @(negedge clk); wr_en = 0;
  endtask

  task automatic rd_chk(input logic [1:0] a, input logic [7:0] msk, input logic [7:0] e, input string tag);
    @(negedge clk); rd_en = 1; addr = a;
    #1 check(tag, 32'(rdata & msk), 32'(e));
    @(negedge clk); rd_en = 0;
  endtask

  task automatic do_reset();
    @(negedge clk); rst_n = 0; ack = 0; wr_en = 0; rd_en = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
  endtask

  initial begin
    #(T * 200000);
    n_bad++;
    $display("FAIL watchdog: actual running expected finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    int n;
    do_reset();
    auto_on = 1;
    // R1 reset state
    check("R1 req", 32'(req), 0);
    check("R1 self_ref", 32'(self_ref), 0);
    for (int a = 0; a < 3; a++) rd_chk(2'(a), 8'hFF, 8'h00, "R1 register");
    // R2 programmable while stopped
    wr(2, 8'h02); wr(1, 8'h37);
    repeat (5) @(negedge clk);
    rd_chk(1, 8'hFF, 8'h37, "R2 counter frozen");
    rd_chk(2, 8'hFF, 8'h02, "R2 compare readback");
    wr(1, 8'h00);
    // R3 period: compare 2, select 3 (div 32) -> 64 clocks
    wr(0, 8'h0D);
    n = 0;
    while (!req && n < 5000) begin @(negedge clk); n++; end
    check("R5 first request", 32'(req), 1);
    ack = 1; n = 0;
    @(negedge clk); ack = 0; n = 1;
    check("R6 ack drops req", 32'(req), 0);
    while (!req && n < 5000) begin @(negedge clk); n++; end
    check("R3 R4 interval div32", 32'(n), 64);
    // R8 flag clear ignored while enabled
    rd_chk(0, 8'h80, 8'h80, "R8 flag set");
    wr(0, 8'h0D);
    rd_chk(0, 8'h80, 8'h80, "R8 clear ignored when enabled");
    wr(0, 8'h00);
    rd_chk(0, 8'h80, 8'h80, "R8 flag still set");
    wr(0, 8'h00);
    rd_chk(0, 8'h80, 8'h00, "R8 flag cleared when disabled");
    // R9 counter write equal to compare does not match
    wr(2, 8'h05); wr(1, 8'h05); wr(0, 8'h05);
    repeat (10) @(negedge clk);
    check("R9 no request from write", 32'(req), 0);
    rd_chk(0, 8'h80, 8'h00, "R9 no flag from write");
    // R7 self-refresh suppresses requests
    wr(2, 8'h02); wr(0, 8'h07);
    repeat (2) @(negedge clk);
    check("R7 self_ref high", 32'(self_ref), 1);
    n = 0;
    repeat (100) begin @(negedge clk); if (req) n++; end
    check("R7 no requests in self-refresh", 32'(n), 0);
    // C = 0 gives 256 ticks, div 2
    do_reset();
    wr(0, 8'h05);
    n = 0;
    while (!req && n < 5000) begin @(negedge clk); n++; end
    ack = 1; @(negedge clk); ack = 0; n = 1;
    while (!req && n < 5000) begin @(negedge clk); n++; end
    check("R4 compare zero interval", 32'(n), 512);
    // random phase
    void'($urandom(32'd1234));
    for (int i = 0; i < 30000; i++) begin
      @(negedge clk);
      wr_en = 0; rd_en = ($urandom % 3) == 0; addr = 2'($urandom % 4);
      ack = ($urandom % 5) == 0;
      if (($urandom % 40) == 0) begin
        wr_en = 1; addr = 2'($urandom % 3);
        case (addr)
          0: wdata = {1'($urandom), 2'b00, 3'(($urandom % 4 == 0) ? $urandom % 8 : 1 + $urandom % 2),
                      1'($urandom % 4 == 0), 1'($urandom % 4 != 0)};
          1: wdata = 8'($urandom % 8);
          default: wdata = 8'($urandom % 6);
        endcase
      end
    end
    @(negedge clk); wr_en = 0; rd_en = 0; ack = 0;
    @(negedge clk);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule